// File: doc/BRIEF.md
# Dual-Bank GPIO Expander Register Core

This block is the register core of a 16-pin general-purpose I/O expander. The pins are grouped into two ports of eight, and each port has its own set of eight-bit registers: input, polarity, direction, output, interrupt mask, hold select and pull direction. A host reaches them over a simple synchronous register bus that has an address, write data, a write strobe, a read strobe and registered read data.

The core drives the pad controls directly. These are the output values, the output enables, and the per-pin hold and pull selections. Incoming pin levels pass through a two-stage synchronizer. They are then checked against a per-port snapshot that is taken whenever software reads that port's input register. Any unmasked pin that differs from its snapshot pulls the shared active-low interrupt low. The interrupt clears when the pin goes back to its snapshot level or when its port is read again. Software should read both input registers before it unmasks any pin, because the snapshots start at zero.

Top module: `gpio_xp_core`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), the output registers are 00h, the polarity registers are 00h, the mask registers are FFh (all masked), the hold-select registers are FFh, the pull-direction registers are 00h, and `irq_n` is 1.
- R2: The register map is fixed. Even addresses select port 0 (pins 7:0) and odd addresses select port 1 (pins 15:8). 0h/1h are input, 2h/3h polarity, 4h/5h hold select, 6h/7h pull direction, 8h/9h direction, Ah/Bh output, Ch/Dh mask. Every writable register reads back the last value written. Addresses Eh and Fh read 00h, and writes to them change nothing.
- R3: `reg_rdata` is loaded on the clock edge at which `reg_rd` is high and holds its value in all other cycles.
- R4: The input registers (0h/1h) are read-only. A write to them changes no register, output or read value.
- R5: Reading an input register returns the synchronized pin level XOR that port's polarity bits. The pin level is reported whether the pin is an input or an output.
- R6: A direction bit of 1 makes the pin an input. `pin_oe` is high exactly for the pins whose direction bit is 0, and `pin_out` carries the output registers.
- R7: `hold_sel` carries the hold-select registers (1 = bus-hold, 0 = resistor). `pull_up` carries the pull-direction registers (1 = pull-up, 0 = pull-down).
- R8: A level change on an unmasked pin drives `irq_n` low two clock edges after the change is applied, and not earlier.
- R9: A level change on a masked pin (mask bit 1) never asserts `irq_n`.
- R10: Reading a port's input register snapshots that port's pins. This clears the interrupt sources of that port only, and a read of the other port leaves them asserted.
- R11: When a changed pin returns to its snapshot level, its interrupt source clears without any read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output values to the pads |
| pin_oe | output | 16 | Output enables, 1 = drive |
| hold_sel | output | 16 | 1 = bus-hold, 0 = pull resistor |
| pull_up | output | 16 | 1 = pull-up, 0 = pull-down |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest situation to reach is one where an interrupt source from one port is still pending while the other port's input register is read. That read must relatch only its own port. The bench first unmasks one pin in each port and aligns both snapshots by reading them. It then flips the port 1 pin and reads port 0 to confirm that the interrupt stays low, and reads port 1 to confirm that it clears. The exact two-edge latency is checked by sampling `irq_n` one edge after a pin flip, when it must still be high, and again at the second edge.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int BANK_W     = 8;
    localparam int N_BANK     = 2;
    localparam int PIN_W      = BANK_W * N_BANK;
    localparam int ADDR_W     = 4;
    localparam int SYNC_DEPTH = 2;
    localparam int BANK_IDX_W = (N_BANK > 1) ? $clog2(N_BANK) : 1;

    typedef logic [BANK_W-1:0] bank_word_t;

    // register kind is the address with the bank bit dropped
    typedef enum logic [2:0] {
        K_INPUT = 3'd0,
        K_POL   = 3'd1,
        K_HOLD  = 3'd2,
        K_PULL  = 3'd3,
        K_DIR   = 3'd4,
        K_OUT   = 3'd5,
        K_MASK  = 3'd6,
        K_NONE  = 3'd7
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e               kind;
        logic [BANK_IDX_W-1:0]   bank;
    } reg_sel_t;

    typedef struct packed {
        bank_word_t pol;
        bank_word_t hold;
        bank_word_t pull;
        bank_word_t dir;
        bank_word_t outv;
        bank_word_t mask;
    } bank_regs_t;

    localparam bank_word_t RST_POL  = '0;
    localparam bank_word_t RST_HOLD = '1;
    localparam bank_word_t RST_PULL = '0;
    localparam bank_word_t RST_DIR  = '1;
    localparam bank_word_t RST_OUT  = '0;
    localparam bank_word_t RST_MASK = '1;

    localparam bank_regs_t BANK_RST = '{
        pol:  RST_POL,
        hold: RST_HOLD,
        pull: RST_PULL,
        dir:  RST_DIR,
        outv: RST_OUT,
        mask: RST_MASK
    };

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] addr);
        reg_sel_t s;
        s.kind = reg_kind_e'(addr[ADDR_W-1:1]);
        s.bank = BANK_IDX_W'(addr[0]);
        return s;
    endfunction

    function automatic bank_word_t pick_field(input bank_regs_t r,
                                              input reg_kind_e  k);
        bank_word_t v;
        case (k)
            K_POL:   v = r.pol;
            K_HOLD:  v = r.hold;
            K_PULL:  v = r.pull;
            K_DIR:   v = r.dir;
            K_OUT:   v = r.outv;
            K_MASK:  v = r.mask;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        snap_en,
    input  reg_kind_e   kind,
    input  bank_word_t  wdata,
    input  bank_word_t  pin_sync,
    output bank_regs_t  regs,
    output bank_word_t  change
);
    bank_word_t snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs   <= BANK_RST;
            snap_q <= '0;
        end else begin
            if (wr_en) begin
                case (kind)
                    K_POL:   regs.pol  <= wdata;
                    K_HOLD:  regs.hold <= wdata;
                    K_PULL:  regs.pull <= wdata;
                    K_DIR:   regs.dir  <= wdata;
                    K_OUT:   regs.outv <= wdata;
                    K_MASK:  regs.mask <= wdata;
                    default: ;
                endcase
            end
            if (snap_en) snap_q <= pin_sync;
        end
    end

    // change detect is on raw levels; polarity only shapes the read view
    always_comb change = (pin_sync ^ snap_q) & ~regs.mask;
endmodule

// File: rtl/gpio_xp_core.sv
module gpio_xp_core
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BANK_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [BANK_W-1:0] reg_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic [PIN_W-1:0]  hold_sel,
    output logic [PIN_W-1:0]  pull_up,
    output logic              irq_n
);
    reg_sel_t         sel;
    logic [PIN_W-1:0] pin_sync;
    bank_regs_t       regs     [N_BANK];
    bank_word_t       change_b [N_BANK];
    bank_word_t       sync_b   [N_BANK];

    always_comb sel = decode_addr(reg_addr);

    gpx_sync #(.WIDTH(PIN_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    generate
        for (genvar b = 0; b < N_BANK; b++) begin : g_bank
            logic hit;
            assign hit         = (sel.bank == BANK_IDX_W'(b));
            assign sync_b[b]   = pin_sync[b*BANK_W +: BANK_W];

            gpx_bank u_bank (
                .clk      (clk),
                .rst      (rst),
                .wr_en    (reg_wr && hit),
                .snap_en  (reg_rd && hit && (sel.kind == K_INPUT)),
                .kind     (sel.kind),
                .wdata    (reg_wdata),
                .pin_sync (sync_b[b]),
                .regs     (regs[b]),
                .change   (change_b[b])
            );

            assign pin_out [b*BANK_W +: BANK_W] = regs[b].outv;
            assign pin_oe  [b*BANK_W +: BANK_W] = ~regs[b].dir;
            assign hold_sel[b*BANK_W +: BANK_W] = regs[b].hold;
            assign pull_up [b*BANK_W +: BANK_W] = regs[b].pull;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            if (sel.kind == K_INPUT)
                reg_rdata <= sync_b[sel.bank] ^ regs[sel.bank].pol;
            else
                reg_rdata <= pick_field(regs[sel.bank], sel.kind);
        end
    end

    always_comb begin
        logic any;
        any = 1'b0;
        for (int b = 0; b < N_BANK; b++) any = any | (|change_b[b]);
        irq_n = ~any;
    end
endmodule

// File: rtl/gpx_core_checker.sv
module gpx_core_checker
    import gpx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BANK_W-1:0] reg_wdata,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [BANK_W-1:0] reg_rdata,
    input logic [PIN_W-1:0]  pin_out,
    input logic [PIN_W-1:0]  pin_oe,
    input logic [PIN_W-1:0]  hold_sel,
    input logic [PIN_W-1:0]  pull_up,
    input logic              irq_n
);
    // R1: reset leaves every pin an input, outputs low, no interrupt
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pin_oe == '0) && (pin_out == '0) && irq_n);

    // R3: read data moves only on a read strobe
    a_r3_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));

    // R4: writes to the input registers touch no pad control
    a_r4_input_write_inert: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr[ADDR_W-1:1] == '0) |=>
            $stable(pin_oe) && $stable(pin_out) && $stable(hold_sel) && $stable(pull_up));

    // R6: a direction write on port 0 sets the enables to its complement
    a_r6_oe_follows_dir: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'h8) |=> pin_oe[BANK_W-1:0] == ~$past(reg_wdata));

    // R6: an output write on port 1 appears on the upper pins
    a_r6_out_follows_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'hB) |=> pin_out[PIN_W-1:BANK_W] == $past(reg_wdata));

    // R7: a hold-select write on port 0 appears on the pad control
    a_r7_hold_follows_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'h4) |=> hold_sel[BANK_W-1:0] == $past(reg_wdata));
endmodule

bind gpio_xp_core gpx_core_checker u_gpx_chk (.*);

// File: tb/test_gpio_xp_core.sv
`timescale 1ns/1ps
module test_gpio_xp_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, hold_sel, pull_up;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_xp_core i_gpio_xp_core (.*);

    // {addr, write data, expected read-back}, pins held at 3C5Ah
    localparam logic [19:0] VEC [12] = '{
        {4'h2, 8'hA5, 8'hA5},
        {4'h3, 8'h0F, 8'h0F},
        {4'h8, 8'hF0, 8'hF0},
        {4'h9, 8'h00, 8'h00},
        {4'hA, 8'h3C, 8'h3C},
        {4'hB, 8'hC3, 8'hC3},
        {4'hC, 8'h7E, 8'h7E},
        {4'hD, 8'h81, 8'h81},
        {4'h4, 8'h55, 8'h55},
        {4'h7, 8'hAA, 8'hAA},
        {4'h0, 8'h12, 8'hFF},   // 5A ^ A5, write ignored
        {4'h1, 8'h34, 8'h33}    // 3C ^ 0F, write ignored
    };

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        tick(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 oe", pin_oe, 16'h0000);
        chk("R1 out", pin_out, 16'h0000);
        chk("R1 hold", hold_sel, 16'hFFFF);
        chk("R1 pull", pull_up, 16'h0000);
        chk("R1 irq", irq_n, 1'b1);
        rd(4'hC, d); chk("R1 mask0", d, 8'hFF);
        rd(4'h9, d); chk("R1 dir1", d, 8'hFF);
        rd(4'h2, d); chk("R1 pol0", d, 8'h00);

        pin_in = 16'h3C5A;
        tick(3);
        for (int i = 0; i < 12; i++) begin
            wr(VEC[i][19:16], VEC[i][15:8]);
            rd(VEC[i][19:16], d);
            chk((VEC[i][19:17] == 3'd0) ? "R5/R4 input view" : "R2 readback", d, VEC[i][7:0]);
        end
        // both ports relatched by the last two reads: R10
        chk("R10 clear after reads", irq_n, 1'b1);
        // R6 R7 pad controls
        chk("R6 oe", pin_oe, 16'hFF0F);
        chk("R6 out", pin_out, 16'hC33C);
        chk("R7 hold", hold_sel, 16'hFF55);
        chk("R7 pull", pull_up, 16'hAA00);
        // R4 input writes inert
        wr(4'h0, 8'h00);
        chk("R4 oe unchanged", pin_oe, 16'hFF0F);
        chk("R4 out unchanged", pin_out, 16'hC33C);
        rd(4'h0, d); chk("R4 input reg", d, 8'hFF);
        // R2 unused address
        wr(4'hE, 8'h77);
        rd(4'hE, d); chk("R2 unused reads zero", d, 8'h00);
        chk("R2 unused write inert", pin_out, 16'hC33C);
        // R3 hold of read data
        wr(4'hA, 8'h99);
        tick(2);
        chk("R3 rdata held", reg_rdata, 8'h00);

        // interrupts: unmask pin0 and pin15 only
        wr(4'hC, 8'hFE);
        wr(4'hD, 8'h7F);
        chk("R8 quiet", irq_n, 1'b1);
        pin_in = 16'h3C5B;
        tick();
        chk("R8 not before two edges", irq_n, 1'b1);
        tick();
        chk("R8 asserted", irq_n, 1'b0);
        pin_in = 16'h3C5A;
        tick(2);
        chk("R11 return clears", irq_n, 1'b1);
        pin_in = 16'h3C58;
        tick(3);
        chk("R9 masked pin", irq_n, 1'b1);
        pin_in = 16'h3C59;
        tick(2);
        chk("R8 asserted again", irq_n, 1'b0);
        rd(4'h0, d);
        chk("R10 port0 read clears", irq_n, 1'b1);
        chk("R5 port0 view", d, 8'hFC);
        pin_in = 16'hBC59;
        tick(2);
        chk("R8 port1 asserted", irq_n, 1'b0);
        rd(4'h0, d);
        chk("R10 other port read keeps", irq_n, 1'b0);
        rd(4'h1, d);
        chk("R10 own port read clears", irq_n, 1'b1);
        chk("R5 port1 view", d, 8'hB3);

        // R1 reset again restores defaults
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 reset out", pin_out, 16'h0000);
        chk("R1 reset oe", pin_oe, 16'h0000);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule